// File: doc/BRIEF.md
# MRU Way-Predicting Set-Associative Lookup

This block is the lookup engine of a four-way set-associative cache. It holds each line's tag, valid bit and data word, and it tries to read only one way per access. For each set it keeps a note of the way that was used last. On an accepted request, only that way's tag and data arrays are strobed. If the predicted way holds the line, the response leaves one cycle later. A read of one way costs about a quarter of a full four-way read.

When the predicted way does not match, the engine uses a second cycle and strobes the remaining three ways together. A hit there is returned one cycle later than a predicted hit. If no way matches, the engine requests the word from the next memory level and places it in a way chosen by a round-robin pointer kept for each set. It then returns the fetched word with the hit flag cleared. Three counters record how each access ended: predicted hit, second-cycle hit or miss. These counters let the surrounding logic judge how well the prediction works.

Requests and responses are valid/ready streams. A request is taken only when the engine is idle and its single response register is empty or is being drained in the same cycle. A response stays stable until the consumer takes it. The refill side is a plain request level and a one-cycle return strobe.

Top module: `wp_cache_lookup`

## Requirements
- R1: After reset, every line is invalid, all three counters read zero, `rsp_valid` and `mem_req_valid` are low, and the first access to any address ends as a miss.
- R2: The request address splits into a set index in the low `$clog2(SETS)` bits and a tag in the bits above it. In the cycle a request is accepted, exactly one bit of `way_tag_rd_en` is set, and `way_data_rd_en` equals it. Bit `i` stands for way `i`, and the set bit is the set's most recently used way.
- R3: When the predicted way holds the line, `rsp_valid` rises one cycle after acceptance with `rsp_hit` = 1 and the line's data, and `cnt_first_hit` grows by one.
- R4: When the predicted way does not match, the cycle after acceptance strobes every way except the predicted one in both strobe vectors. If one of them holds the line, the response arrives two cycles after acceptance with `rsp_hit` = 1, and `cnt_second_hit` grows by one.
- R5: When no way matches, `mem_req_valid` rises two cycles after acceptance with `mem_req_addr` equal to the request address. It stays high until `mem_rsp_valid` is seen. The line is written to the set's round-robin way. That pointer starts at way 0 and steps by one, modulo four, on each fill of that set. The cycle after `mem_rsp_valid`, the response carries `mem_rsp_data` with `rsp_hit` = 0, and `cnt_miss` grows by one.
- R6: A hit in the second cycle and a fill both make the involved way the set's most recently used way. A predicted hit leaves it unchanged.
- R7: While `rsp_valid` is high and `rsp_ready` is low, the response data and hit flag hold, and `req_ready` is low. `req_ready` is also low during the probe and refill cycles. A response drained in the same cycle that a new request is accepted does not block that request.
- R8: No strobe bit is set in a cycle where no request is accepted, except for the probe cycle of R4.
- R9: Prediction, round-robin and line state are kept per set. An access to one set never changes another set's predicted way, victim choice or lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Engine can accept a request |
| req_addr | input | TAG_W+$clog2(SETS) | Word address: tag above set index |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Data word of the line |
| rsp_hit | output | 1 | 1 when the line was resident, 0 when it was fetched |
| way_tag_rd_en | output | WAYS | Per-way tag array read strobe |
| way_data_rd_en | output | WAYS | Per-way data array read strobe |
| mem_req_valid | output | 1 | Refill request level |
| mem_req_addr | output | TAG_W+$clog2(SETS) | Address to fetch |
| mem_rsp_valid | input | 1 | Refill data strobe |
| mem_rsp_data | input | DATA_W | Refill data word |
| cnt_first_hit | output | CNT_W | Count of predicted hits |
| cnt_second_hit | output | CNT_W | Count of second-cycle hits |
| cnt_miss | output | CNT_W | Count of misses |

## Verification
Two functions can fall in the same clock edge. One is the drain of a finished response. The other is the acceptance of the next request, which on a predicted hit reloads the same response register. The bench provokes this by driving a new request in the same cycle that a response is first visible with `rsp_ready` high, and it mixes this with responses held back for several cycles. A computed model of lines, predicted way and round-robin pointer per set gives the expected strobe pattern, latency, data and counters. The data expected for each address is an arithmetic function of that address, which the refill side also returns. A lost or duplicated response, a wrong strobe or a counter step out of place therefore shows up as a miscompare.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    ST_LOOK  = 2'd0,
    ST_PROBE = 2'd1,
    ST_FILL  = 2'd2
  } wp_state_e;

  localparam int EV_FIRST  = 0;
  localparam int EV_SECOND = 1;
  localparam int EV_MISS   = 2;
  localparam int EV_N      = 3;
endpackage

// File: rtl/wp_way_array.sv
module wp_way_array #(
  parameter int SETS   = 16,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_en,
  input  logic              data_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  cmp_tag,
  output logic              hit,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      dat_q[wr_idx] <= wr_data;
    end
  end

  // a read only sees the array when its strobe is up
  assign hit     = tag_en && vld_q[rd_idx] && (tag_q[rd_idx] == cmp_tag);
  assign rd_data = data_en ? dat_q[rd_idx] : '0;

  // R5: a written line is valid afterwards
  a_r5_fill_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/wp_set_state.sv
module wp_set_state #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [WAY_W-1:0] lk_mru,
  input  logic [IDX_W-1:0] up_idx,
  output logic [WAY_W-1:0] up_victim,
  input  logic             hit_upd,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_upd
);
  logic [WAY_W-1:0] mru_q [SETS];
  logic [WAY_W-1:0] rr_q  [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        mru_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else if (hit_upd) begin
      mru_q[up_idx] <= hit_way;
    end else if (fill_upd) begin
      mru_q[up_idx] <= rr_q[up_idx];
      rr_q[up_idx]  <= (rr_q[up_idx] == WAY_W'(WAYS-1)) ? '0 : rr_q[up_idx] + 1'b1;
    end
  end

  assign lk_mru    = mru_q[lk_idx];
  assign up_victim = rr_q[up_idx];

  // R6: a set is updated by one cause per cycle
  a_r6_one_update: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_upd && fill_upd));
  // R5: every fill moves the set's round-robin pointer on
  a_r5_rr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    fill_upd |=> (rr_q[$past(up_idx)] != $past(up_victim)));
endmodule

// File: rtl/wp_event_counters.sv
module wp_event_counters #(
  parameter int CNT_W = 16,
  parameter int N_EV  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_EV-1:0]            ev,
  output logic [N_EV-1:0][CNT_W-1:0] cnt
);
  for (genvar e = 0; e < N_EV; e++) begin : g_ev
    logic [CNT_W-1:0] c_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) c_q <= '0;
      else if (ev[e]) c_q <= c_q + 1'b1;
    end
    assign cnt[e] = c_q;
  end

  // R3: one access ends in one way only
  a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev));
endmodule

// File: rtl/wp_cache_lookup.sv
module wp_cache_lookup
  import wp_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int SETS   = 16,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic [WAYS-1:0]   way_tag_rd_en,
  output logic [WAYS-1:0]   way_data_rd_en,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [CNT_W-1:0]  cnt_first_hit,
  output logic [CNT_W-1:0]  cnt_second_hit,
  output logic [CNT_W-1:0]  cnt_miss
);
  wp_state_e         state, state_nx;
  logic [ADDR_W-1:0] addr_q;
  logic [WAYS-1:0]   pred_oh_q;
  logic              rsp_valid_q, rsp_hit_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic              req_fire;
  logic [IDX_W-1:0]  req_idx, cur_idx, q_idx;
  logic [TAG_W-1:0]  req_tag, cur_tag, q_tag;
  logic [WAY_W-1:0]  lk_mru, victim, hit_way;
  logic [WAYS-1:0]   pred_oh, way_sel, hit_v, wr_v;
  logic [DATA_W-1:0] rd_w [WAYS];
  logic              any_hit;
  logic [DATA_W-1:0] sel_data, load_data;
  logic              load_rsp, load_hit, hit_upd, fill_upd;
  logic [EV_N-1:0]   ev;
  logic [EV_N-1:0][CNT_W-1:0] cnt;

  assign req_idx = req_addr[IDX_W-1:0];
  assign req_tag = req_addr[ADDR_W-1:IDX_W];
  assign q_idx   = addr_q[IDX_W-1:0];
  assign q_tag   = addr_q[ADDR_W-1:IDX_W];

  assign req_ready = (state == ST_LOOK) && (!rsp_valid_q || rsp_ready);
  assign req_fire  = req_valid && req_ready;

  assign cur_idx = (state == ST_LOOK) ? req_idx : q_idx;
  assign cur_tag = (state == ST_LOOK) ? req_tag : q_tag;
  assign pred_oh = WAYS'(1) << lk_mru;

  // strobe pattern: predicted way on acceptance, the rest in the probe cycle
  always_comb begin
    way_sel = '0;
    if (state == ST_LOOK && req_fire) way_sel = pred_oh;
    else if (state == ST_PROBE)       way_sel = ~pred_oh_q;
  end
  assign way_tag_rd_en  = way_sel;
  assign way_data_rd_en = way_sel;

  wp_set_state #(.SETS(SETS), .WAYS(WAYS)) u_set_state (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(req_idx), .lk_mru(lk_mru),
    .up_idx(q_idx), .up_victim(victim),
    .hit_upd(hit_upd), .hit_way(hit_way), .fill_upd(fill_upd)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wr_v[w] = fill_upd && (victim == WAY_W'(w));
    wp_way_array #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_way (
      .clk(clk), .rst_n(rst_n),
      .tag_en(way_tag_rd_en[w]), .data_en(way_data_rd_en[w]),
      .rd_idx(cur_idx), .cmp_tag(cur_tag),
      .hit(hit_v[w]), .rd_data(rd_w[w]),
      .wr_en(wr_v[w]), .wr_idx(q_idx), .wr_tag(q_tag), .wr_data(mem_rsp_data)
    );
  end

  assign any_hit = |hit_v;
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (hit_v[w]) hit_way = WAY_W'(w);
  end
  assign sel_data = rd_w[hit_way];

  always_comb begin
    state_nx  = state;
    load_rsp  = 1'b0;
    load_data = sel_data;
    load_hit  = 1'b1;
    ev        = '0;
    hit_upd   = 1'b0;
    fill_upd  = 1'b0;
    case (state)
      ST_LOOK: begin
        if (req_fire) begin
          if (any_hit) begin
            load_rsp      = 1'b1;
            ev[EV_FIRST]  = 1'b1;
          end else begin
            state_nx = ST_PROBE;
          end
        end
      end
      ST_PROBE: begin
        if (any_hit) begin
          load_rsp      = 1'b1;
          ev[EV_SECOND] = 1'b1;
          hit_upd       = 1'b1;
          state_nx      = ST_LOOK;
        end else begin
          state_nx = ST_FILL;
        end
      end
      ST_FILL: begin
        if (mem_rsp_valid) begin
          load_rsp    = 1'b1;
          load_data   = mem_rsp_data;
          load_hit    = 1'b0;
          ev[EV_MISS] = 1'b1;
          fill_upd    = 1'b1;
          state_nx    = ST_LOOK;
        end
      end
      default: state_nx = ST_LOOK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_LOOK;
      addr_q      <= '0;
      pred_oh_q   <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      rsp_hit_q   <= 1'b0;
    end else begin
      state <= state_nx;
      if (req_fire) begin
        addr_q    <= req_addr;
        pred_oh_q <= pred_oh;
      end
      if (rsp_valid_q && rsp_ready) rsp_valid_q <= 1'b0;
      if (load_rsp) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= load_data;
        rsp_hit_q   <= load_hit;
      end
    end
  end

  assign rsp_valid     = rsp_valid_q;
  assign rsp_data      = rsp_data_q;
  assign rsp_hit       = rsp_hit_q;
  assign mem_req_valid = (state == ST_FILL);
  assign mem_req_addr  = addr_q;

  wp_event_counters #(.CNT_W(CNT_W), .N_EV(EV_N)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ev(ev), .cnt(cnt)
  );
  assign cnt_first_hit  = cnt[EV_FIRST];
  assign cnt_second_hit = cnt[EV_SECOND];
  assign cnt_miss       = cnt[EV_MISS];

  // R2: one way strobed on acceptance, tag and data alike
  a_r2_single_way: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |-> ($countones(way_tag_rd_en) == 1) && (way_data_rd_en == way_tag_rd_en));
  // R3: a predicted hit answers on the next cycle
  a_r3_pred_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && any_hit) |=> rsp_valid && rsp_hit);
  // R4: probe covers every way but the predicted one
  a_r4_probe_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROBE) |-> ($countones(way_tag_rd_en) == WAYS-1) && ((way_tag_rd_en & pred_oh_q) == '0));
  // R5: refill request holds until served
  a_r5_memreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> mem_req_valid && $stable(mem_req_addr));
  // R7: stalled response holds and blocks new requests
  a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data) && $stable(rsp_hit));
  a_r7_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  // R8: no strobes without an accepted request outside the probe
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && state != ST_PROBE) |-> (way_tag_rd_en == '0) && (way_data_rd_en == '0));
endmodule

// File: tb/tb_wp_cache_lookup.sv
module tb_wp_cache_lookup;
  localparam int WAYS = 4, SETS = 4, TAG_W = 4, DATA_W = 16, CNT_W = 16;
  localparam int IDX_W = 2, ADDR_W = TAG_W + IDX_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b1, mem_rsp_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] mem_rsp_data = '0;
  logic req_ready, rsp_valid, rsp_hit, mem_req_valid;
  logic [DATA_W-1:0] rsp_data;
  logic [WAYS-1:0] way_tag_rd_en, way_data_rd_en;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [CNT_W-1:0] cnt_first_hit, cnt_second_hit, cnt_miss;

  always #5 clk = ~clk;

  wp_cache_lookup #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .way_tag_rd_en(way_tag_rd_en), .way_data_rd_en(way_data_rd_en),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .cnt_first_hit(cnt_first_hit), .cnt_second_hit(cnt_second_hit), .cnt_miss(cnt_miss));

  int n_chk = 0, n_bad = 0;
  bit          m_v   [SETS][WAYS];
  int          m_t   [SETS][WAYS];
  int          m_mru [SETS];
  int          m_rr  [SETS];
  int          e_first = 0, e_second = 0, e_miss = 0;

  function automatic logic [DATA_W-1:0] memf(input int a);
    return DATA_W'((a * 40503) ^ 16'h3C5A);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_cnt(input string tag);
    chk(cnt_first_hit == CNT_W'(e_first), {tag, " first-hit count"}, cnt_first_hit, e_first);
    chk(cnt_second_hit == CNT_W'(e_second), {tag, " second-hit count"}, cnt_second_hit, e_second);
    chk(cnt_miss == CNT_W'(e_miss), {tag, " miss count"}, cnt_miss, e_miss);
  endtask

  // one lookup; b2b = drive in the current cycle, next to a visible response
  task automatic access(input int a, input int hold, input bit b2b, input int lat);
    int s, t, w, kind;
    logic [WAYS-1:0] poh;
    s = a % SETS; t = a / SETS; w = -1;
    for (int i = 0; i < WAYS; i++) if (m_v[s][i] && m_t[s][i] == t) w = i;
    kind = (w == m_mru[s]) ? 0 : (w >= 0 ? 1 : 2);
    poh = WAYS'(1) << m_mru[s];
    if (!b2b) @(negedge clk);
    req_valid = 1'b1; req_addr = ADDR_W'(a);
    #1;
    chk(req_ready == 1'b1, "R7 ready when idle", req_ready, 1);
    chk(way_tag_rd_en == poh, "R2 R9 predicted tag strobe", way_tag_rd_en, poh);
    chk(way_data_rd_en == poh, "R2 predicted data strobe", way_data_rd_en, poh);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    if (kind == 0) begin
      e_first++;
      chk(way_tag_rd_en == '0, "R8 no strobe after predicted hit", way_tag_rd_en, 0);
    end else begin
      chk(rsp_valid == 1'b0, "R4 no response in probe cycle", rsp_valid, 0);
      chk(req_ready == 1'b0, "R7 ready low in probe", req_ready, 0);
      chk(way_tag_rd_en == (~poh & 4'hF), "R4 probe tag strobes", way_tag_rd_en, ~poh & 4'hF);
      chk(way_data_rd_en == (~poh & 4'hF), "R4 probe data strobes", way_data_rd_en, ~poh & 4'hF);
      @(negedge clk); #1;
      if (kind == 1) begin
        e_second++;
        m_mru[s] = w;
      end else begin
        chk(mem_req_valid == 1'b1, "R5 refill request", mem_req_valid, 1);
        chk(mem_req_addr == ADDR_W'(a), "R5 refill address", mem_req_addr, a);
        chk(way_tag_rd_en == '0, "R8 no strobe while refilling", way_tag_rd_en, 0);
        chk(rsp_valid == 1'b0, "R5 no response before refill", rsp_valid, 0);
        for (int k = 0; k < lat; k++) begin
          @(negedge clk); #1;
          chk(mem_req_valid == 1'b1, "R5 refill request held", mem_req_valid, 1);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = memf(a);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        #1;
        e_miss++;
        m_v[s][m_rr[s]] = 1'b1; m_t[s][m_rr[s]] = t;
        m_mru[s] = m_rr[s];
        m_rr[s] = (m_rr[s] + 1) % WAYS;
        chk(mem_req_valid == 1'b0, "R5 refill request drops", mem_req_valid, 0);
      end
    end
    chk(rsp_valid == 1'b1, kind == 0 ? "R3 response after one cycle" :
        (kind == 1 ? "R4 response after two cycles" : "R5 response after refill"), rsp_valid, 1);
    chk(rsp_hit == (kind != 2), kind == 2 ? "R5 hit flag clear" : "R3 R6 hit flag set", rsp_hit, kind != 2);
    chk(rsp_data == memf(a), kind == 2 ? "R5 refill data" : "R3 R4 R6 line data", rsp_data, memf(a));
    chk_cnt(kind == 0 ? "R3" : (kind == 1 ? "R4" : "R5"));
    if (hold > 0) begin
      rsp_ready = 1'b0;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk); #1;
        chk(rsp_valid == 1'b1 && rsp_data == memf(a), "R7 held response", rsp_data, memf(a));
        chk(req_ready == 1'b0, "R7 ready low while stalled", req_ready, 0);
      end
      rsp_ready = 1'b1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lcg, a;
    for (int s = 0; s < SETS; s++) begin
      m_mru[s] = 0; m_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin m_v[s][w] = 1'b0; m_t[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    #1;
    chk(rsp_valid == 1'b0, "R1 no response in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(mem_req_valid == 1'b0, "R1 no refill after reset", mem_req_valid, 0);
    chk(way_tag_rd_en == '0, "R8 idle strobes", way_tag_rd_en, 0);
    chk_cnt("R1");
    // fill each set past its capacity: round-robin eviction, per-set state
    for (int t = 0; t < 6; t++)
      for (int s = 0; s < SETS; s++)
        access(t * SETS + s, (t + s) % 3, 1'b0, s % 3);
    // revisit lines in every set: mispredicts and second-cycle hits
    for (int t = 2; t < 6; t++)
      for (int s = 0; s < SETS; s++)
        access(t * SETS + s, 0, (t + s) % 2 == 1, 0);
    // pseudo-random mix over the whole address space
    lcg = 12345;
    for (int i = 0; i < 600; i++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      a = (lcg >> 8) % (1 << ADDR_W);
      if (i % 5 == 0) a = a % 24;
      access(a, (i % 7 == 0) ? 2 : 0, (i % 4 == 1), i % 3);
    end
    // same line back to back: drain and accept in one edge
    for (int i = 0; i < 10; i++) access(7, 0, i != 0, 0);
    @(negedge clk); #1;
    chk(rsp_valid == 1'b0, "R7 last response drained", rsp_valid, 0);
    chk(way_tag_rd_en == '0, "R8 quiet at end", way_tag_rd_en, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule